// File: doc/BRIEF.md
# DMA Page Address Formation Unit

This block keeps an 8-bit page value for each DMA channel that has one (channels 0 to 3 and 5 to 7) and makes them reachable through a simple I/O write/read port. While a transfer is running, it joins the page of the active channel to that channel's 16-bit current address to give a 24-bit system address. The address counter and the channel arbiter sit outside this block. The page value is a constant during a transfer: the block never increments it.

Channels that count bytes use the page as address bits 23:16 above the 16-bit current address. Channels that count 16-bit words shift the current address up one place. Bit 15 of the current address then becomes system address bit 16, replacing page bit 0, and system address bit 0 is zero. The caller picks the mode with the word-mode input; normally it is high for channels 5 to 7. Channel 4 has no page register, so it contributes a page of zero.

Top module: `dma_page_addr`

## Requirements
- R1: After reset, `sys_addr` and `io_rdata` are both 0.
- R2: A write (`io_wr` high) to a page port stores `io_wdata` as that channel's page. The 16-bit port addresses are: channel 2 = 0x0081, channel 3 = 0x0082, channel 1 = 0x0083, channel 0 = 0x0087, channel 6 = 0x0089, channel 7 = 0x008A, channel 5 = 0x008B.
- R3: A read (`io_rd` high) of a page port returns that channel's page on `io_rdata` one cycle later. `io_rdata` is 0 in any cycle that does not follow a read.
- R4: A read of an address that is not a page port returns 0, and a write to such an address changes no page.
- R5: In byte mode (`word_mode` = 0), one cycle after a cycle with `xfer_active` high, `sys_addr` = {page of `chan`, `cur_addr`}.
- R6: In word mode (`word_mode` = 1), one cycle after a cycle with `xfer_active` high, `sys_addr` = {page[7:1], `cur_addr`, 1'b0}. Page bit 0 has no effect.
- R7: No carry from the current address reaches the page field. With `cur_addr` = 0xFFFF in byte mode, bits 23:16 equal the page unchanged.
- R8: One cycle after a cycle with `xfer_active` low, `sys_addr` is 0.
- R9: Channel 4 (`chan` = 4) supplies a page of 0.
- R10: A page write in the same cycle as a transfer on that channel takes effect from the next transfer cycle. The address formed in that cycle uses the page held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Registered I/O read data |
| chan | input | 3 | Active DMA channel number |
| cur_addr | input | 16 | Current address of the active channel |
| word_mode | input | 1 | 1 = 16-bit word-count channel |
| xfer_active | input | 1 | A transfer cycle is in progress |
| sys_addr | output | 24 | Registered 24-bit system address |

## Verification
Every result is one register away from its stimulus. A page write is visible from the following clock edge. Read data appears on the edge after the read strobe is sampled, and so does the system address for a transfer cycle. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge, so each check sees the value due for its own stimulus. The same-cycle write-and-transfer case is sampled on two successive falling edges: the first must show the old page and the second the new one.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;

    // I/O port of each channel's page register; 0 means no page register
    function automatic logic [7:0] page_port(input int unsigned ch);
        case (ch)
            0:       return 8'h87;
            1:       return 8'h83;
            2:       return 8'h81;
            3:       return 8'h82;
            5:       return 8'h8B;
            6:       return 8'h89;
            7:       return 8'h8A;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic has_page(input int unsigned ch);
        return (ch < 8) && (ch != 4);
    endfunction

endpackage

// File: rtl/page_decode.sv
module page_decode #(
    parameter int IO_AW = 16,
    parameter int CH_W  = 3
) (
    input  logic [IO_AW-1:0] io_addr,
    output logic             hit,
    output logic [CH_W-1:0]  sel
);
    import dma_page_pkg::*;

    localparam int NCH = 1 << CH_W;

    logic [NCH-1:0] match;

    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        if (has_page(i)) begin : g_port
            localparam logic [IO_AW-1:0] PORT = IO_AW'(page_port(i));
            assign match[i] = (io_addr == PORT);
        end else begin : g_none
            assign match[i] = 1'b0;
        end
    end

    always_comb begin
        hit = |match;
        sel = '0;
        for (int i = 0; i < NCH; i++) begin
            if (match[i]) sel = CH_W'(i);
        end
    end

endmodule

// File: rtl/page_regfile.sv
module page_regfile #(
    parameter int CH_W   = 3,
    parameter int PAGE_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [CH_W-1:0]                wsel,
    input  logic [PAGE_W-1:0]              wdata,
    output logic [(1<<CH_W)-1:0][PAGE_W-1:0] pages
);
    import dma_page_pkg::*;

    localparam int NCH = 1 << CH_W;

    typedef struct packed {
        logic [NCH-1:0][PAGE_W-1:0] pg;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we && has_page(32'(wsel))) begin
            regs_d.pg[wsel] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign pages = regs_q.pg;

endmodule

// File: rtl/addr_former.sv
module addr_former #(
    parameter int PAGE_W = 8,
    parameter int CA_W   = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   xfer_active,
    input  logic                   word_mode,
    input  logic [PAGE_W-1:0]      page,
    input  logic [CA_W-1:0]        cur_addr,
    output logic [PAGE_W+CA_W-1:0] sys_addr
);
    localparam int AW = PAGE_W + CA_W;

    typedef struct packed {
        logic [AW-1:0] addr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.addr = '0;
        if (xfer_active) begin
            if (word_mode) st_d.addr = {page[PAGE_W-1:1], cur_addr, 1'b0};
            else           st_d.addr = {page, cur_addr};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sys_addr = st_q.addr;

endmodule

// File: rtl/dma_page_addr.sv
module dma_page_addr #(
    parameter int IO_AW  = 16,
    parameter int CH_W   = 3,
    parameter int PAGE_W = 8,
    parameter int CA_W   = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   io_wr,
    input  logic                   io_rd,
    input  logic [IO_AW-1:0]       io_addr,
    input  logic [PAGE_W-1:0]      io_wdata,
    output logic [PAGE_W-1:0]      io_rdata,
    input  logic [CH_W-1:0]        chan,
    input  logic [CA_W-1:0]        cur_addr,
    input  logic                   word_mode,
    input  logic                   xfer_active,
    output logic [PAGE_W+CA_W-1:0] sys_addr
);
    localparam int NCH = 1 << CH_W;

    typedef struct packed {
        logic [PAGE_W-1:0] rdata;
    } rd_t;

    logic                        dec_hit;
    logic [CH_W-1:0]             dec_sel;
    logic [NCH-1:0][PAGE_W-1:0]  pages;
    rd_t                         rd_d, rd_q;

    page_decode #(.IO_AW(IO_AW), .CH_W(CH_W)) u_dec (
        .io_addr (io_addr),
        .hit     (dec_hit),
        .sel     (dec_sel)
    );

    page_regfile #(.CH_W(CH_W), .PAGE_W(PAGE_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (io_wr && dec_hit),
        .wsel  (dec_sel),
        .wdata (io_wdata),
        .pages (pages)
    );

    addr_former #(.PAGE_W(PAGE_W), .CA_W(CA_W)) u_form (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_active (xfer_active),
        .word_mode   (word_mode),
        .page        (pages[chan]),
        .cur_addr    (cur_addr),
        .sys_addr    (sys_addr)
    );

    always_comb begin
        rd_d.rdata = '0;
        if (io_rd && dec_hit) rd_d.rdata = pages[dec_sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign io_rdata = rd_q.rdata;

endmodule

// File: rtl/dma_page_addr_chk.sv
module dma_page_addr_chk #(
    parameter int IO_AW  = 16,
    parameter int CH_W   = 3,
    parameter int PAGE_W = 8,
    parameter int CA_W   = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   io_rd,
    input logic [IO_AW-1:0]       io_addr,
    input logic [PAGE_W-1:0]      io_rdata,
    input logic [CH_W-1:0]        chan,
    input logic [CA_W-1:0]        cur_addr,
    input logic                   word_mode,
    input logic                   xfer_active,
    input logic [PAGE_W+CA_W-1:0] sys_addr
);
    localparam int AW = PAGE_W + CA_W;

    logic mapped;
    assign mapped = (io_addr == IO_AW'(8'h81)) || (io_addr == IO_AW'(8'h82)) ||
                    (io_addr == IO_AW'(8'h83)) || (io_addr == IO_AW'(8'h87)) ||
                    (io_addr == IO_AW'(8'h89)) || (io_addr == IO_AW'(8'h8A)) ||
                    (io_addr == IO_AW'(8'h8B));

    assert_rdata_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> io_rdata == '0);

    assert_unmapped_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !mapped) |=> io_rdata == '0);

    assert_byte_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && !word_mode) |=> sys_addr[CA_W-1:0] == $past(cur_addr));

    assert_word_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && word_mode) |=> sys_addr[CA_W:0] == {$past(cur_addr), 1'b0});

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> sys_addr == '0);

    assert_chan4_nopage_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && chan == CH_W'(4)) |=> sys_addr[AW-1:CA_W+1] == '0);

endmodule

bind dma_page_addr dma_page_addr_chk #(
    .IO_AW(IO_AW), .CH_W(CH_W), .PAGE_W(PAGE_W), .CA_W(CA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_rd       (io_rd),
    .io_addr     (io_addr),
    .io_rdata    (io_rdata),
    .chan        (chan),
    .cur_addr    (cur_addr),
    .word_mode   (word_mode),
    .xfer_active (xfer_active),
    .sys_addr    (sys_addr)
);

// File: tb/dma_page_addr_test.sv
`timescale 1ns/1ps
module dma_page_addr_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [2:0]  chan = '0;
    logic [15:0] cur_addr = '0;
    logic        word_mode = 1'b0;
    logic        xfer_active = 1'b0;
    logic [23:0] sys_addr;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] pg [8];

    always #2.5 clk = ~clk;

    dma_page_addr uut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .chan(chan), .cur_addr(cur_addr), .word_mode(word_mode),
        .xfer_active(xfer_active), .sys_addr(sys_addr)
    );

    function automatic logic [15:0] port_of(input int ch);
        case (ch)
            0: return 16'h0087;
            1: return 16'h0083;
            2: return 16'h0081;
            3: return 16'h0082;
            5: return 16'h008B;
            6: return 16'h0089;
            7: return 16'h008A;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input logic [23:0] act,
                         input logic [23:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read_check(input logic [15:0] a, input logic [7:0] exp,
                                 input string req);
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        @(negedge clk);
        io_rd = 1'b0;
        check(io_rdata == exp, req, 24'(io_rdata), 24'(exp));
    endtask

    task automatic xfer_check(input int ch, input logic [15:0] ca, input logic wm,
                              input logic [23:0] exp, input string req);
        @(negedge clk);
        xfer_active = 1'b1; chan = 3'(ch); cur_addr = ca; word_mode = wm;
        @(negedge clk);
        xfer_active = 1'b0;
        check(sys_addr == exp, req, sys_addr, exp);
    endtask

    task automatic t_reset;
        check(sys_addr == '0, "R1 sys_addr", sys_addr, 24'h0);
        check(io_rdata == '0, "R1 io_rdata", 24'(io_rdata), 24'h0);
    endtask

    task automatic t_write_read;
        for (int c = 0; c < 8; c++) begin
            if (c != 4) begin
                pg[c] = 8'(8'h10 * c + 8'h05 + c);
                io_write(port_of(c), pg[c]);
            end
        end
        for (int c = 0; c < 8; c++) begin
            if (c != 4) io_read_check(port_of(c), pg[c], "R2/R3 readback");
        end
        @(negedge clk);
        check(io_rdata == '0, "R3 idle rdata", 24'(io_rdata), 24'h0);
    endtask

    task automatic t_unmapped;
        io_read_check(16'h0080, 8'h00, "R4 unmapped read");
        io_read_check(16'h0084, 8'h00, "R4 unmapped read 84");
        io_write(16'h0187, 8'hAA);
        io_write(16'h0088, 8'hAA);
        io_read_check(port_of(0), pg[0], "R4 write ignored ch0");
        io_read_check(port_of(6), pg[6], "R4 write ignored ch6");
    endtask

    task automatic t_byte;
        xfer_check(0, 16'h1234, 1'b0, {pg[0], 16'h1234}, "R5 byte ch0");
        xfer_check(3, 16'hA5C3, 1'b0, {pg[3], 16'hA5C3}, "R5 byte ch3");
        pg[2] = 8'h7F;
        io_write(port_of(2), pg[2]);
        xfer_check(2, 16'hFFFF, 1'b0, 24'h7FFFFF, "R7 no carry");
    endtask

    task automatic t_word;
        pg[5] = 8'h35;
        io_write(port_of(5), pg[5]);
        xfer_check(5, 16'h8001, 1'b1, 24'h350002, "R6 word bit15 set");
        xfer_check(5, 16'h0001, 1'b1, 24'h340002, "R6 word page bit0 dropped");
        xfer_check(7, 16'hFFFF, 1'b1, {pg[7][7:1], 16'hFFFF, 1'b0}, "R6 word ch7");
    endtask

    task automatic t_idle_chan4;
        @(negedge clk);
        xfer_active = 1'b0; chan = 3'd0; cur_addr = 16'hFFFF;
        @(negedge clk);
        check(sys_addr == '0, "R8 idle", sys_addr, 24'h0);
        xfer_check(4, 16'hBEEF, 1'b0, 24'h00BEEF, "R9 chan4 byte");
        xfer_check(4, 16'hBEEF, 1'b1, 24'h017DDE, "R9 chan4 word");
    endtask

    task automatic t_same_cycle;
        logic [7:0] old_pg;
        old_pg = pg[1];
        pg[1] = 8'hC6;
        @(negedge clk);
        io_wr = 1'b1; io_addr = port_of(1); io_wdata = pg[1];
        xfer_active = 1'b1; chan = 3'd1; cur_addr = 16'h0F0F; word_mode = 1'b0;
        @(negedge clk);
        io_wr = 1'b0;
        check(sys_addr == {old_pg, 16'h0F0F}, "R10 old page", sys_addr, {old_pg, 16'h0F0F});
        @(negedge clk);
        xfer_active = 1'b0;
        check(sys_addr == {pg[1], 16'h0F0F}, "R10 new page", sys_addr, {pg[1], 16'h0F0F});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_unmapped();
        t_byte();
        t_word();
        t_idle_chan4();
        t_same_cycle();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule